// File: doc/BRIEF.md
# Page Protection Rights Decoder

This unit settles the rights of one already-translated memory access. It takes the protection attributes that the surrounding translation logic has collected (the key bits and the no-execute bit of the segment, the current privilege state, and the second word of the matching page entry), forms an access key and a protection code, and turns them into a three-bit rights vector of read, write and execute. It then compares the kind of access against that vector and reports either a grant or a protection fault.

Two modes are supported. In the narrow (32-bit) mode the code is two bits wide and only the segment can forbid execution. In the wide (64-bit) mode the page word adds a third code bit, and both a page-level no-execute bit and a guarded bit also forbid execution. An instruction fetch in a segment marked no-execute is refused at segment level, before any page rights would apply. This refusal is flagged separately and reports an empty rights vector.

The caller presents all inputs together with a one-cycle valid strobe. The verdict appears on the registered outputs on the following cycle and stays there until the next strobe. Finding the page entry and forming the physical address are done elsewhere.

Top module: `prot_rights_unit`

## Requirements
- R1: The access key is 1 when `user_mode`=1 and `seg_ukey`=1, or when `user_mode`=0 and `seg_skey`=1; otherwise it is 0.
- R2: In narrow mode (`mode64`=0) the protection code is {0, `page_word[1:0]`}. In wide mode `page_word[63]` is the top code bit. `page_word[63]` is ignored in narrow mode.
- R3: With key 0, the rights vector (bit 0 read, bit 1 write, bit 2 execute) holds read and write for codes 0, 1 and 2. It holds read only for codes 3 and 6, and neither for codes 4, 5 and 7.
- R4: With key 1, codes 1 and 3 give read only and code 2 gives read and write. Codes 0, 4, 5, 6 and 7 give neither.
- R5: The execute bit is set exactly when the no-execute flag is 0. In wide mode the flag is `seg_nx` OR `page_word[2]` OR `page_word[3]`. In narrow mode it is `seg_nx` alone, and `page_word[3:2]` are ignored.
- R6: For `acc_type` 2 (fetch) the grant follows the execute bit. For 1 (write) it follows the write bit. For 0 (read) and for 3 it follows the read bit. Exactly one of `granted` and `fault` is 1 on every result.
- R7: A fetch with `seg_nx`=1 gives `seg_reject`=1, `fault`=1 and an all-zero rights vector, whatever the page word holds. Every other access gives `seg_reject`=0.
- R8: A result appears on the registered outputs in the cycle after `req_valid`, and `res_valid` is high for that one cycle. Without a strobe, `rights`, `granted`, `fault` and `seg_reject` keep their values.
- R9: While reset is held, all outputs are 0, which means no rights, no grant, no fault and no valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Strobe: the inputs below form one access to evaluate |
| mode64 | input | 1 | 1 selects wide-mode decoding of the page word |
| user_mode | input | 1 | 1 when the processor is in user state |
| seg_ukey | input | 1 | Segment key bit used in user state |
| seg_skey | input | 1 | Segment key bit used in supervisor state |
| seg_nx | input | 1 | Segment forbids instruction fetch |
| page_word | input | 64 | Second word of the matching page entry |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| res_valid | output | 1 | One-cycle pulse: a new verdict is on the outputs |
| rights | output | 3 | Bit 0 read, bit 1 write, bit 2 execute |
| granted | output | 1 | The access is allowed |
| fault | output | 1 | The access violates protection |
| seg_reject | output | 1 | The fault came from the segment no-execute rule |

## Verification
On every cycle, the bound checker confirms several relations. Each result is either a grant or a fault, never both. The write right never appears without the read right. The grant agrees with the rights bit that the strobed access type selects. A fetch in a no-execute segment always ends as a segment-level fault. Outputs do not move without a strobe, and the valid pulse follows the strobe by exactly one cycle. Whether the rights themselves are correct can only be shown by the bench's scenarios. These sweep every key source, every three-bit code in both modes, every combination of the three no-execute sources and every access type, while junk sits in the page-word bits that must be ignored.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_SPARE = 2'd3
  } acc_e;

  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
  localparam int RT_EX = 2;
  localparam int RT_W  = 3;

  typedef logic [RT_W-1:0] rights_t;

endpackage

// File: rtl/prot_key_sel.sv
module prot_key_sel (
  input  logic user_mode,
  input  logic ukey,
  input  logic skey,
  output logic key
);

  always_comb begin
    key = (user_mode & ukey) | (~user_mode & skey);
  end

endmodule

// File: rtl/prot_code_map.sv
module prot_code_map
  import prot_pkg::*;
#(
  parameter int PAGE_W      = 64,
  parameter int CODE_HI_POS = PAGE_W - 1,
  parameter int PNX_POS     = 2,
  parameter int GRD_POS     = 3
) (
  input  logic              mode64,
  input  logic [PAGE_W-1:0] page_word,
  input  logic              seg_nx,
  input  logic              key,
  output rights_t           rights_o
);

  localparam int CODE_W = 3;

  logic [CODE_W-1:0] code;
  logic              nx_flag;
  logic              rd;
  logic              wr;
  logic              unused_page_bits;

  assign unused_page_bits = ^page_word[CODE_HI_POS-1:GRD_POS+1];

  // protection code: the top bit only counts in wide mode
  always_comb begin
    code = {mode64 & page_word[CODE_HI_POS], page_word[1:0]};
  end

  // execute is forbidden by the segment, and in wide mode also by the page
  always_comb begin
    nx_flag = seg_nx | (mode64 & (page_word[PNX_POS] | page_word[GRD_POS]));
  end

  // key 0 is permissive for low codes, key 1 is the stricter table
  always_comb begin
    rd = 1'b0;
    wr = 1'b0;
    if (!key) begin
      case (code)
        3'd0, 3'd1, 3'd2: begin rd = 1'b1; wr = 1'b1; end
        3'd3, 3'd6:       begin rd = 1'b1; end
        default:          begin rd = 1'b0; wr = 1'b0; end
      endcase
    end else begin
      case (code)
        3'd1, 3'd3: begin rd = 1'b1; end
        3'd2:       begin rd = 1'b1; wr = 1'b1; end
        default:    begin rd = 1'b0; wr = 1'b0; end
      endcase
    end
  end

  always_comb begin
    rights_o        = '0;
    rights_o[RT_RD] = rd;
    rights_o[RT_WR] = wr;
    rights_o[RT_EX] = ~nx_flag;
  end

endmodule

// File: rtl/prot_access_gate.sv
module prot_access_gate
  import prot_pkg::*;
(
  input  acc_e    acc,
  input  logic    seg_nx,
  input  rights_t page_rights,
  output rights_t rights_o,
  output logic    grant,
  output logic    seg_rej
);

  logic need_ok;

  always_comb begin
    seg_rej = (acc == ACC_FETCH) & seg_nx;
  end

  always_comb begin
    case (acc)
      ACC_FETCH: need_ok = page_rights[RT_EX];
      ACC_STORE: need_ok = page_rights[RT_WR];
      default:   need_ok = page_rights[RT_RD];
    endcase
  end

  always_comb begin
    rights_o = seg_rej ? '0 : page_rights;
    grant    = need_ok & ~seg_rej;
  end

endmodule

// File: rtl/prot_rights_unit.sv
module prot_rights_unit
  import prot_pkg::*;
#(
  parameter int PAGE_W      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              mode64,
  input  logic              user_mode,
  input  logic              seg_ukey,
  input  logic              seg_skey,
  input  logic              seg_nx,
  input  logic [PAGE_W-1:0] page_word,
  input  logic [1:0]        acc_type,
  output logic              res_valid,
  output logic [RT_W-1:0]   rights,
  output logic              granted,
  output logic              fault,
  output logic              seg_reject
);

  localparam int SYNC_LAST = SYNC_STAGES - 1;

  // reset: asserts at once, leaves after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe[SYNC_LAST];

  // decode path
  acc_e    acc_in;
  logic    key;
  rights_t page_rights;
  rights_t gated_rights;
  logic    grant_c;
  logic    segrej_c;

  assign acc_in = acc_e'(acc_type);

  prot_key_sel i_key (
    .user_mode (user_mode),
    .ukey      (seg_ukey),
    .skey      (seg_skey),
    .key       (key)
  );

  prot_code_map #(
    .PAGE_W (PAGE_W)
  ) i_map (
    .mode64    (mode64),
    .page_word (page_word),
    .seg_nx    (seg_nx),
    .key       (key),
    .rights_o  (page_rights)
  );

  prot_access_gate i_gate (
    .acc         (acc_in),
    .seg_nx      (seg_nx),
    .page_rights (page_rights),
    .rights_o    (gated_rights),
    .grant       (grant_c),
    .seg_rej     (segrej_c)
  );

  // result registers: next state, then state
  rights_t rights_q, rights_d;
  logic    grant_q, grant_d;
  logic    fault_q, fault_d;
  logic    segrej_q, segrej_d;
  logic    valid_q, valid_d;

  always_comb begin
    valid_d  = req_valid;
    rights_d = rights_q;
    grant_d  = grant_q;
    fault_d  = fault_q;
    segrej_d = segrej_q;
    if (req_valid) begin
      rights_d = gated_rights;
      grant_d  = grant_c;
      fault_d  = ~grant_c;
      segrej_d = segrej_c;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q  <= 1'b0;
      rights_q <= '0;
      grant_q  <= 1'b0;
      fault_q  <= 1'b0;
      segrej_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      rights_q <= rights_d;
      grant_q  <= grant_d;
      fault_q  <= fault_d;
      segrej_q <= segrej_d;
    end
  end

  assign res_valid  = valid_q;
  assign rights     = rights_q;
  assign granted    = grant_q;
  assign fault      = fault_q;
  assign seg_reject = segrej_q;

endmodule

// File: rtl/prot_rights_chk.sv
module prot_rights_chk
  import prot_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            seg_nx,
  input logic [1:0]      acc_type,
  input logic            res_valid,
  input logic [RT_W-1:0] rights,
  input logic            granted,
  input logic            fault,
  input logic            seg_reject
);

  assert_one_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (granted ^ fault));

  assert_write_implies_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(rights[RT_WR] && !rights[RT_RD]));

  assert_fetch_follows_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_type == ACC_FETCH) |=> (granted == rights[RT_EX]));

  assert_store_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_type == ACC_STORE) |=> (granted == rights[RT_WR]));

  assert_seg_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_type == ACC_FETCH && seg_nx) |=>
      (seg_reject && fault && rights == '0));

  assert_no_seg_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(acc_type == ACC_FETCH && seg_nx)) |=> !seg_reject);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_valid_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rights) && $stable(granted) &&
                    $stable(fault) && $stable(seg_reject)));

endmodule

bind prot_rights_unit prot_rights_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .req_valid  (req_valid),
  .seg_nx     (seg_nx),
  .acc_type   (acc_type),
  .res_valid  (res_valid),
  .rights     (rights),
  .granted    (granted),
  .fault      (fault),
  .seg_reject (seg_reject)
);

// File: tb/test_prot_rights_unit.sv
module test_prot_rights_unit;
  import prot_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        mode64;
  logic        user_mode;
  logic        seg_ukey;
  logic        seg_skey;
  logic        seg_nx;
  logic [63:0] page_word;
  logic [1:0]  acc_type;
  logic        res_valid;
  logic [2:0]  rights;
  logic        granted;
  logic        fault;
  logic        seg_reject;

  prot_rights_unit i_prot_rights_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .mode64     (mode64),
    .user_mode  (user_mode),
    .seg_ukey   (seg_ukey),
    .seg_skey   (seg_skey),
    .seg_nx     (seg_nx),
    .page_word  (page_word),
    .acc_type   (acc_type),
    .res_valid  (res_valid),
    .rights     (rights),
    .granted    (granted),
    .fault      (fault),
    .seg_reject (seg_reject)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected item layout: {rights[2:0], granted, fault, seg_reject}
  logic [5:0] exp_q[$];
  string      tag_q[$];
  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 0;
  int         cycles   = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] model(input bit m, input bit u, input bit uk,
                                       input bit sk, input bit snx,
                                       input logic [63:0] pw, input logic [1:0] a);
    bit       k;
    bit [2:0] c;
    bit       r, w, x, nx, g;
    k  = (u && uk) || (!u && sk);
    c  = m ? {pw[63], pw[1:0]} : {1'b0, pw[1:0]};
    r  = 0;
    w  = 0;
    if (k == 0) begin
      if (c <= 3'd2) begin r = 1; w = 1; end
      else if (c == 3'd3 || c == 3'd6) r = 1;
    end else begin
      if (c == 3'd1 || c == 3'd3) r = 1;
      else if (c == 3'd2) begin r = 1; w = 1; end
    end
    nx = snx || (m && (pw[2] || pw[3]));
    x  = !nx;
    if (a == 2'd2 && snx) return {3'b000, 1'b0, 1'b1, 1'b1};
    g = (a == 2'd2) ? x : (a == 2'd1) ? w : r;
    return {x, w, r, g, !g, 1'b0};
  endfunction

  task automatic send(input bit m, input bit u, input bit uk, input bit sk,
                      input bit snx, input logic [63:0] pw, input logic [1:0] a,
                      input string tag);
    mode64    = m;
    user_mode = u;
    seg_ukey  = uk;
    seg_skey  = sk;
    seg_nx    = snx;
    page_word = pw;
    acc_type  = a;
    req_valid = 1'b1;
    exp_q.push_back(model(m, u, uk, sk, snx, pw, a));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares each result against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected result", {rights, granted, fault, seg_reject}, 6'b0);
      end else begin
        logic [5:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rights, granted, fault, seg_reject} == e, t,
              {rights, granted, fault, seg_reject}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000 && !done) begin
      done = 1;
      n_fail++;
      n_checks++;
      $display("FAIL R8 watchdog expired actual=%0d expected<=%0d", cycles, 60000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [5:0]  held;
    logic [63:0] pw;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    mode64    = 1'b0;
    user_mode = 1'b0;
    seg_ukey  = 1'b0;
    seg_skey  = 1'b0;
    seg_nx    = 1'b0;
    page_word = '0;
    acc_type  = 2'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check({res_valid, rights, granted, fault, seg_reject} == 7'b0, "R9 reset outputs",
          {rights, granted, fault, seg_reject}, 6'b0);
    check(res_valid == 1'b0, "R9 reset valid", {5'b0, res_valid}, 6'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // sweep: R1 key sources, R2 code forms, R3/R4 tables, R5 nx sources,
    // R6 access kinds, R7 segment-level fetch refusal
    for (int m = 0; m < 2; m++)
      for (int ks = 0; ks < 8; ks++)
        for (int c = 0; c < 8; c++)
          for (int n = 0; n < 8; n++)
            for (int a = 0; a < 4; a++) begin
              bit    u, uk, sk, k;
              string t;
              u  = ks[2];
              uk = ks[1];
              sk = ks[0];
              k  = (u && uk) || (!u && sk);
              pw = 64'h3A5C_96E1_0F4B_D270;
              pw[63]  = c[2];
              pw[1:0] = c[1:0];
              pw[2]   = n[1];
              pw[3]   = n[2];
              if (a == 2 && n[0])
                t = $sformatf("R7 m=%0d code=%0d", m, c);
              else
                t = $sformatf("%s R1 R2 R5 R6 m=%0d u=%0d uk=%0d sk=%0d code=%0d nx=%0d acc=%0d",
                              k ? "R4" : "R3", m, u, uk, sk, c, n, a);
              send(m[0], u, uk, sk, n[0], pw, a[1:0], t);
            end
    req_valid = 1'b0;
    @(negedge clk);

    // R8: a result holds while inputs change without a strobe
    pw = 64'h0000_0000_0000_0002;
    send(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, pw, 2'd1, "R8 hold setup");
    req_valid = 1'b0;
    held = model(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, pw, 2'd1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      mode64    = ~mode64;
      user_mode = ~user_mode;
      seg_ukey  = 1'b1;
      seg_nx    = 1'b1;
      page_word = ~page_word;
      acc_type  = 2'd2;
      @(negedge clk);
      check(res_valid == 1'b0 && {rights, granted, fault, seg_reject} == held,
            "R8 outputs held without strobe",
            {rights, granted, fault, seg_reject}, held);
    end

    check(exp_q.size() == 0, "R8 all results delivered", exp_q.size(), 6'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule